// File: doc/BRIEF.md
# Pipelined velocity-form PID controller

This block is a synchronous fixed-point discrete PID controller that works in the incremental (velocity) form. Each accepted error sample e(n) yields one new controller output u(n). The output is formed as the previous output plus a weighted sum of the current error and the two errors before it. The three tap weights are supplied already combined from the proportional, integral and derivative gains and the sample period. For a period Ts they are: current tap Kp + Ki·Ts + Kd/Ts, previous tap -(Kp + 2·Kd/Ts), and oldest tap Kd/Ts. This sets the controller in backward-difference form, and the block itself needs no knowledge of Ts.

The three products are formed in parallel, one per tap, by identical pipelined multipliers. They are rounded back to the data width. Two parallel-prefix adder stages then sum them into an increment and add it to the saturated running output. A new sample may enter on every clock, and the valid strobe travels beside the data with a fixed latency.

Top module: `pid_velocity_ctrl`

## Requirements
- R1: For each accepted sample, u(n) = clamp(u(n-1) + r(k_cur·e(n)) + r(k_prev1·e(n-1)) + r(k_prev2·e(n-2))). The taps are signed two's-complement values with FRAC fractional bits (default 12, so 4096 means 1.0). Errors and outputs are signed DW-bit integers. u, e(n-1) and e(n-2) are zero after reset.
- R2: Each product is rounded as r(p) = floor((p + 2^(FRAC-1)) / 2^FRAC) and then clamped to the signed DW-bit range before it is summed. A tie rounds toward plus infinity.
- R3: out_valid pulses for exactly one cycle per accepted sample, MUL_STAGES+2 clock edges after the edge that accepted it. Samples may arrive on consecutive clocks, and outputs leave in arrival order.
- R4: The error history moves (e(n-2) takes e(n-1), and e(n-1) takes the new error) only on an edge where in_valid is high. err_in and the tap inputs are ignored while in_valid is low.
- R5: Tap values are sampled together with the error on the accepting edge. Changing them later does not affect a sample that is already in flight.
- R6: The accumulated output saturates at -2^(DW-1) and 2^(DW-1)-1. The saturated value is fed back as u(n-1).
- R7: A synchronous active-high reset clears the error history, the output and every in-flight sample. After the reset edge out_valid is 0 and u_out is 0, and samples accepted before the reset never appear.
- R8: u_out keeps its value in every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | err_in and the taps are accepted on this edge |
| err_in | input | DW | Signed error sample |
| k_cur | input | CW | Signed tap for the current error |
| k_prev1 | input | CW | Signed tap for the previous error |
| k_prev2 | input | CW | Signed tap for the error two samples back |
| out_valid | output | 1 | One-cycle strobe for a new u_out |
| u_out | output | DW | Signed controller output |

## Verification
The bench builds the block with its default parameters: 20-bit data, 20-bit taps with 12 fractional bits, and an 8-stage multiplier, which gives a 10-edge latency. A full-scale tap times a full-scale error then overflows the 20-bit product range by far, so product clamping, the half-LSB rounding tie in both signs and output saturation in both directions can all be reached with legal inputs. The bench also runs a long back-to-back stream, so ten samples are in flight at once while taps and errors change every clock. A reset is issued while samples are in flight.

// File: rtl/pidv_pkg.sv
package pidv_pkg;

    // Clamp a signed value into the range of a signed field of 'bits' bits.
    function automatic longint clamp_s(input longint v, input int bits);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (bits - 1)) - 1;
        lo = -(longint'(1) <<< (bits - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/pidv_prefix_add.sv
module pidv_prefix_add #(
    parameter int W = 20
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] sum_out
);
    localparam int L = $clog2(W);

    // Group generate / propagate per level; level 0 is per bit.
    logic [W-1:0] g [0:L];
    logic [W-1:0] p [0:L-1];

    assign g[0] = a_in & b_in;
    assign p[0] = a_in ^ b_in;

    for (genvar lv = 0; lv < L; lv++) begin : g_lvl
        localparam int SPAN = 1 << lv;
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= SPAN) begin : g_op
                // carry operator: (g,p) o (g',p') = (g | p&g', p&p')
                assign g[lv+1][i] = g[lv][i] | (p[lv][i] & g[lv][i-SPAN]);
                if (lv + 1 < L) begin : g_pp
                    assign p[lv+1][i] = p[lv][i] & p[lv][i-SPAN];
                end
            end else begin : g_pass
                assign g[lv+1][i] = g[lv][i];
                if (lv + 1 < L) begin : g_pp
                    assign p[lv+1][i] = p[lv][i];
                end
            end
        end
    end

    assign sum_out = p[0] ^ {g[L][W-2:0], 1'b0};

    logic             unused_carry;
    logic [W-1:0]     unused_ptop;
    assign unused_carry = g[L][W-1];
    assign unused_ptop  = p[L-1];

endmodule

// File: rtl/pidv_pipe_mul.sv
module pidv_pipe_mul #(
    parameter int AW     = 20,
    parameter int BW     = 20,
    parameter int STAGES = 8
) (
    input  logic                 clk,
    input  logic [AW-1:0]        a_in,
    input  logic [BW-1:0]        b_in,
    output logic [AW+BW-1:0]     p_out
);
    localparam int PW = AW + BW;
    localparam int H  = BW / 2;
    localparam int LW = AW + H + 1;
    localparam int HW = AW + BW - H;
    localparam int D  = STAGES - 3;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [BW-1:0] b;
        logic [LW-1:0] lo;
        logic [HW-1:0] hi;
        logic [PW-1:0] prod;
    } mst_t;

    mst_t          cur_q;
    mst_t          nxt_d;
    logic [PW-1:0] comb_w;

    // Stage 3: recombine the two partial products.
    pidv_prefix_add #(.W(PW)) u_comb (
        .a_in   ({cur_q.hi, {H{1'b0}}}),
        .b_in   (PW'($signed(cur_q.lo))),
        .sum_out(comb_w)
    );

    always_comb begin
        nxt_d      = cur_q;
        // Stage 1: operand capture
        nxt_d.a    = a_in;
        nxt_d.b    = b_in;
        // Stage 2: unsigned low half and signed high half of b
        nxt_d.lo   = LW'($signed(cur_q.a)) * LW'($signed({1'b0, cur_q.b[H-1:0]}));
        nxt_d.hi   = HW'($signed(cur_q.a)) * HW'($signed(cur_q.b[BW-1:H]));
        nxt_d.prod = comb_w;
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    if (D > 0) begin : g_dly
        logic [PW-1:0] dly_q [0:D-1];
        always_ff @(posedge clk) begin
            dly_q[0] <= cur_q.prod;
            for (int j = 1; j < D; j++) begin
                dly_q[j] <= dly_q[j-1];
            end
        end
        assign p_out = dly_q[D-1];
    end else begin : g_nodly
        assign p_out = cur_q.prod;
    end

endmodule

// File: rtl/pid_velocity_ctrl.sv
module pid_velocity_ctrl #(
    parameter int DW         = 20,
    parameter int CW         = 20,
    parameter int FRAC       = 12,
    parameter int MUL_STAGES = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] err_in,
    input  logic [CW-1:0] k_cur,
    input  logic [CW-1:0] k_prev1,
    input  logic [CW-1:0] k_prev2,
    output logic          out_valid,
    output logic [DW-1:0] u_out
);
    import pidv_pkg::*;

    localparam int     PW     = DW + CW;
    localparam int     SW     = DW + 2;
    localparam int     AW     = DW + 3;
    localparam int     NTAP   = 3;
    localparam longint HALF   = longint'(1) <<< (FRAC - 1);
    localparam logic signed [DW-1:0] U_MAX = DW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [DW-1:0] U_MIN = DW'(-(1 <<< (DW - 1)));
    localparam logic signed [AW-1:0] A_MAX = AW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [AW-1:0] A_MIN = AW'(-(1 <<< (DW - 1)));

    typedef struct packed {
        logic signed [DW-1:0]   e1;
        logic signed [DW-1:0]   e2;
        logic signed [DW-1:0]   u;
        logic signed [SW-1:0]   inc;
        logic [MUL_STAGES-1:0]  vp;
        logic                   inc_v;
        logic                   out_v;
    } cst_t;

    cst_t cur_q;
    cst_t nxt_d;

    logic [DW-1:0]        tap_e [NTAP];
    logic [CW-1:0]        tap_k [NTAP];
    logic [PW-1:0]        prod  [NTAP];
    logic signed [DW-1:0] rnd   [NTAP];
    logic [SW-1:0]        s01_w;
    logic [SW-1:0]        inc_w;
    logic [AW-1:0]        acc_w;

    assign tap_e[0] = err_in;
    assign tap_e[1] = cur_q.e1;
    assign tap_e[2] = cur_q.e2;
    assign tap_k[0] = k_cur;
    assign tap_k[1] = k_prev1;
    assign tap_k[2] = k_prev2;

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        pidv_pipe_mul #(.AW(DW), .BW(CW), .STAGES(MUL_STAGES)) u_mul (
            .clk  (clk),
            .a_in (tap_e[t]),
            .b_in (tap_k[t]),
            .p_out(prod[t])
        );
    end

    // Round each product to the data grid and clamp it.
    always_comb begin
        for (int t = 0; t < NTAP; t++) begin
            rnd[t] = DW'(clamp_s((longint'($signed(prod[t])) + HALF) >>> FRAC, DW));
        end
    end

    pidv_prefix_add #(.W(SW)) u_sum01 (
        .a_in   (SW'(rnd[0])),
        .b_in   (SW'(rnd[1])),
        .sum_out(s01_w)
    );

    pidv_prefix_add #(.W(SW)) u_sum2 (
        .a_in   (s01_w),
        .b_in   (SW'(rnd[2])),
        .sum_out(inc_w)
    );

    pidv_prefix_add #(.W(AW)) u_acc (
        .a_in   (AW'($signed(cur_q.u))),
        .b_in   (AW'($signed(cur_q.inc))),
        .sum_out(acc_w)
    );

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.vp = {cur_q.vp[MUL_STAGES-2:0], in_valid};
        if (in_valid) begin
            nxt_d.e1 = err_in;
            nxt_d.e2 = cur_q.e1;
        end
        nxt_d.inc_v = cur_q.vp[MUL_STAGES-1];
        nxt_d.inc   = inc_w;
        nxt_d.out_v = cur_q.inc_v;
        if (cur_q.inc_v) begin
            nxt_d.u = DW'(clamp_s(longint'($signed(acc_w)), DW));
        end
        if (rst) begin
            nxt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign out_valid = cur_q.out_v;
    assign u_out     = cur_q.u;

    // R4: history follows accepted samples only
    p_hist_shift_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (cur_q.e1 == $past(err_in)) && (cur_q.e2 == $past(cur_q.e1)));

    p_hist_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cur_q.e1) && $stable(cur_q.e2));

    // R6: accumulator clamps at both rails
    p_sat_hi_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_q.inc_v && ($signed(acc_w) > A_MAX)) |=> ($signed(u_out) == U_MAX));

    p_sat_lo_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_q.inc_v && ($signed(acc_w) < A_MIN)) |=> ($signed(u_out) == U_MIN));

    // R8: output only moves on an update
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cur_q.inc_v |=> $stable(u_out));

    // R7: reset empties state
    p_reset_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && (u_out == '0) && (cur_q.e1 == '0) && (cur_q.e2 == '0)));

endmodule

// File: tb/sim_pid_velocity_ctrl.sv
`timescale 1ns/1ps
module sim_pid_velocity_ctrl;
    localparam int DW   = 20;
    localparam int CW   = 20;
    localparam int FRAC = 12;
    localparam int S    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] err_in = '0;
    logic [CW-1:0] k_cur = '0;
    logic [CW-1:0] k_prev1 = '0;
    logic [CW-1:0] k_prev2 = '0;
    logic          out_valid;
    logic [DW-1:0] u_out;

    pid_velocity_ctrl #(.DW(DW), .CW(CW), .FRAC(FRAC), .MUL_STAGES(S)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .err_in(err_in),
        .k_cur(k_cur), .k_prev1(k_prev1), .k_prev2(k_prev2),
        .out_valid(out_valid), .u_out(u_out)
    );

    always #2.5 clk = ~clk;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    longint      cyc = 0;
    longint      last_u = 0;
    longint      m_e1 = 0;
    longint      m_e2 = 0;
    longint      m_u = 0;
    longint      exp_q[$];
    longint      due_q[$];
    string       cur_tag = "R1";
    int unsigned rs = 32'h1234_5678;

    function automatic longint clampv(input longint v, input int bits);
        longint hi = (longint'(1) <<< (bits - 1)) - 1;
        longint lo = -(longint'(1) <<< (bits - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint rprod(input longint k, input longint e);
        longint p = k * e;
        return clampv((p + (longint'(1) <<< (FRAC - 1))) >>> FRAC, DW);
    endfunction

    function automatic longint rr(input int unsigned m);
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return longint'(rs % (2 * m + 1)) - longint'(m);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic observe();
        longint act;
        act = longint'($signed(u_out));
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            chk(out_valid === 1'b1, "R3 out_valid", longint'(out_valid), 1);
            chk(act == exp_q[0], cur_tag, act, exp_q[0]);
            last_u = exp_q[0];
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
        end else begin
            chk(out_valid === 1'b0, "R3 out_valid", longint'(out_valid), 0);
            chk(act == last_u, "R8 hold", act, last_u);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        cyc++;
        @(negedge clk);
        observe();
    endtask

    task automatic step(input bit v, input longint e, input longint k0,
                        input longint k1, input longint k2);
        longint inc;
        in_valid = v;
        err_in   = DW'(e);
        k_cur    = CW'(k0);
        k_prev1  = CW'(k1);
        k_prev2  = CW'(k2);
        if (v) begin
            inc  = rprod(k0, e) + rprod(k1, m_e1) + rprod(k2, m_e2);
            m_u  = clampv(m_u + inc, DW);
            m_e2 = m_e1;
            m_e1 = e;
            exp_q.push_back(m_u);
            due_q.push_back(cyc + 1 + S + 1);
        end
        tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0, rr(524287), rr(524287), rr(524287), rr(524287));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        exp_q.delete();
        due_q.delete();
        m_e1 = 0; m_e2 = 0; m_u = 0; last_u = 0;
        tick();
        chk(out_valid === 1'b0 && u_out == '0, "R7 reset",
            longint'($signed(u_out)), 0);
        tick();
        rst = 1'b0;
    endtask

    initial begin
        do_reset();

        // R1: impulse response through all three taps
        cur_tag = "R1 impulse";
        step(1'b1, 100, 8192, -6144, 1024);
        idle(3);
        step(1'b1, 0, 8192, -6144, 1024);
        step(1'b1, 0, 8192, -6144, 1024);
        step(1'b1, -37, 8192, -6144, 1024);
        idle(14);

        // R3: back-to-back stream, taps and errors change every clock
        cur_tag = "R3 stream";
        for (int i = 0; i < 40; i++) begin
            step(1'b1, rr(2000), rr(16384), rr(16384), rr(16384));
        end
        idle(14);

        // R4: sparse samples, garbage on the inputs between them
        cur_tag = "R4 sparse";
        for (int i = 0; i < 12; i++) begin
            step(1'b1, rr(3000), rr(8192), rr(8192), rr(8192));
            idle(1 + (i % 4));
        end
        idle(14);

        // R5: taps sampled with the error, then changed while in flight
        cur_tag = "R5 tap capture";
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 500, 4096 + i * 1000, -2048, 512);
            step(1'b0, 500, -200000, 200000, -200000);
        end
        idle(14);

        // R2: rounding ties and product clamping
        do_reset();
        cur_tag = "R2 rounding";
        step(1'b1, 2048, 1, 0, 0);
        step(1'b1, -2048, 1, 0, 0);
        step(1'b1, 2047, 1, 0, 0);
        step(1'b1, -2049, 1, 0, 0);
        step(1'b1, 524287, 524287, 0, 0);
        step(1'b1, 524287, -524288, 0, 0);
        step(1'b1, -524288, -524288, 524287, 0);
        idle(14);

        // R6: drive into both output rails
        do_reset();
        cur_tag = "R6 saturation";
        for (int i = 0; i < 5; i++) step(1'b1, 5000, 409600, 0, 0);
        for (int i = 0; i < 8; i++) step(1'b1, -5000, 409600, 0, 0);
        for (int i = 0; i < 3; i++) step(1'b1, 4000, 409600, 0, 0);
        idle(14);

        // R7: reset with samples in flight; none may emerge
        cur_tag = "R7 flush";
        for (int i = 0; i < 5; i++) step(1'b1, rr(1000), 4096, 0, 0);
        do_reset();
        idle(14);
        cur_tag = "R7 restart";
        step(1'b1, 10, 4096, 0, 0);
        idle(14);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule